// File: doc/BRIEF.md
# Segment-Register Address Translation Unit

This unit turns a 32-bit per-process effective address into a 52-bit global virtual address. The top 10 bits of the effective address select one of 1024 segment slots. Each slot holds a 30-bit global segment identifier and a 2-bit access mode. The response joins the slot's identifier to the 22 low offset bits, which pass through unchanged. Because the offset is never altered, a downstream cache can index with it while the slot lookup is still in progress.

Every access is checked against the slot's mode. The unit returns either the global address or a fault code, one cycle after the request is accepted. Slots are loaded through a simple write port. Several slots may carry the same identifier, each with its own mode, so one global segment can appear at several places in an address space without a second global name. When a live slot is reloaded with a different identifier, the unit pulses a flush request so that cached data tagged with the old global address can be discarded.

Top module: `seg_xlate`

## Requirements
- R1: A synchronous reset puts every slot in the invalid mode and holds `rspValid` and `flushReq` low.
- R2: `reqReady` is high from the second clock edge after reset is released. A request is accepted when `reqValid` and `reqReady` are both high. Each accepted request gives exactly one `rspValid` pulse in the following cycle, and cycles without an accepted request give none.
- R3: On success, `rspAddr` is the slot identifier in bits 51:22 and `reqAddr[21:0]` in bits 21:0. The slot is chosen by `reqAddr[31:22]`.
- R4: The mode encoding is 00 invalid, 01 read-only, 10 read-write and 11 read-only copy-on-write. A read of a slot in mode 01, 10 or 11 succeeds, and so does a write to a slot in mode 10.
- R5: The fault encoding is 00 none, 01 unmapped, 10 protection and 11 copy-on-write. Any access to a mode-00 slot gives 01. A write to mode 01 gives 10. A write to mode 11 gives 11.
- R6: A faulted response carries an `rspAddr` of all zeros.
- R7: A slot write applies to requests accepted on later edges. A request accepted on the same edge as the write sees the slot's earlier contents.
- R8: Slots that share one identifier translate to the same global segment, and each slot applies its own mode. This is not an error.
- R9: `flushReq` is high for exactly the one cycle after a slot write, and only when the overwritten slot was valid (mode not 00) and the new identifier differs from the old one. It stays low when the identifier is unchanged or when the old slot was invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWrEn | input | 1 | Slot write strobe |
| cfgIdx | input | 10 | Slot to write |
| cfgSid | input | 30 | Global segment identifier to load |
| cfgMode | input | 2 | Access mode to load |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Unit can accept a request |
| reqAddr | input | 32 | Effective address |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| rspValid | output | 1 | Response present |
| rspAddr | output | 52 | Global virtual address, zero on a fault |
| rspFault | output | 2 | Fault code |
| flushReq | output | 1 | Reloaded slot changed identifier |

## Verification
The hardest case to reach from the ports is a slot write and a request for the same slot landing on the same edge. In that case the request must see the slot's earlier contents. The bench drives both strobes in one cycle at a slot that was invalid, checks for the unmapped fault, and then repeats the request to see the new mapping. The flush rules also need a set sequence of reloads: a new identifier over a live slot, the same identifier with a changed mode, a write into an invalid slot, and a reload that invalidates a live slot.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_RO   = 2'b01,
    MODE_RW   = 2'b10,
    MODE_COW  = 2'b11
  } segMode_e;

  typedef enum logic [1:0] {
    FLT_OK       = 2'b00,
    FLT_UNMAPPED = 2'b01,
    FLT_PROT     = 2'b10,
    FLT_COW      = 2'b11
  } fault_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   capture;
    logic   tblWrite;
    fault_e fault;
  } strobe_t;

endpackage

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     reqValid,
  input  logic     reqWrite,
  input  logic     cfgWrEn,
  input  segMode_e lookupMode,
  output logic     reqReady,
  output strobe_t  strobe
);

  logic   readyQ;
  fault_e faultComb;

  always_ff @(posedge clk) begin
    if (rst) readyQ <= 1'b0;
    else     readyQ <= 1'b1;
  end

  assign reqReady = readyQ;

  always_comb begin
    unique case (lookupMode)
      MODE_NONE: faultComb = FLT_UNMAPPED;
      MODE_RO:   faultComb = reqWrite ? FLT_PROT : FLT_OK;
      MODE_RW:   faultComb = FLT_OK;
      MODE_COW:  faultComb = reqWrite ? FLT_COW : FLT_OK;
      default:   faultComb = FLT_UNMAPPED;
    endcase
  end

  always_comb begin
    strobe.capture  = reqValid && readyQ;
    strobe.tblWrite = cfgWrEn;
    strobe.fault    = faultComb;
  end

  // R2: once out of reset the unit stays ready
  assert_ready_after_reset_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> reqReady);

  // R5: reads never raise a write-only fault
  assert_read_no_write_fault_R5: assert property (@(posedge clk) disable iff (rst)
    (strobe.capture && !reqWrite) |-> (strobe.fault != FLT_PROT && strobe.fault != FLT_COW));

endmodule

// File: rtl/seg_xlate_dp.sv
module seg_xlate_dp
  import seg_xlate_pkg::*;
#(
  parameter int SEG_BITS = 10,
  parameter int OFF_BITS = 22,
  parameter int SID_W    = 30
) (
  input  logic                         clk,
  input  logic                         rst,
  input  strobe_t                      strobe,
  input  logic [SEG_BITS-1:0]          cfgIdx,
  input  logic [SID_W-1:0]             cfgSid,
  input  logic [1:0]                   cfgMode,
  input  logic [SEG_BITS+OFF_BITS-1:0] reqAddr,
  input  logic                         reqWrite,
  output segMode_e                     lookupMode,
  output logic                         rspValid,
  output logic [SID_W+OFF_BITS-1:0]    rspAddr,
  output logic [1:0]                   rspFault,
  output logic                         flushReq
);

  localparam int EA_W  = SEG_BITS + OFF_BITS;
  localparam int GVA_W = SID_W + OFF_BITS;
  localparam int SLOTS = 1 << SEG_BITS;

  logic [SID_W-1:0] sidTbl  [SLOTS];
  segMode_e         modeTbl [SLOTS];

  logic [SEG_BITS-1:0] segIdx;
  logic [SID_W-1:0]    lookupSid;
  logic [OFF_BITS-1:0] segOff;
  logic                flushNext;
  logic                wasWrite;

  assign segIdx     = reqAddr[EA_W-1 -: SEG_BITS];
  assign segOff     = reqAddr[OFF_BITS-1:0];
  assign lookupMode = modeTbl[segIdx];
  assign lookupSid  = sidTbl[segIdx];

  assign flushNext = strobe.tblWrite && (modeTbl[cfgIdx] != MODE_NONE)
                     && (sidTbl[cfgIdx] != cfgSid);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) modeTbl[i] <= MODE_NONE;
    end else if (strobe.tblWrite) begin
      modeTbl[cfgIdx] <= segMode_e'(cfgMode);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.tblWrite) sidTbl[cfgIdx] <= cfgSid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid <= 1'b0;
      rspAddr  <= '0;
      rspFault <= FLT_OK;
      wasWrite <= 1'b0;
      flushReq <= 1'b0;
    end else begin
      rspValid <= strobe.capture;
      flushReq <= flushNext;
      if (strobe.capture) begin
        rspFault <= strobe.fault;
        wasWrite <= reqWrite;
        rspAddr  <= (strobe.fault == FLT_OK) ? {lookupSid, segOff} : {GVA_W{1'b0}};
      end
    end
  end

  // R2: every accepted request is answered on the next cycle
  assert_capture_answered_R2: assert property (@(posedge clk) disable iff (rst)
    strobe.capture |=> rspValid);

  // R3: the offset reaches the output unchanged
  assert_offset_passthru_R3: assert property (@(posedge clk) disable iff (rst)
    (rspValid && rspFault == FLT_OK) |-> rspAddr[OFF_BITS-1:0] == $past(reqAddr[OFF_BITS-1:0]));

  // R5: protection and copy-on-write faults only come from writes
  assert_write_faults_R5: assert property (@(posedge clk) disable iff (rst)
    (rspValid && (rspFault == FLT_PROT || rspFault == FLT_COW)) |-> wasWrite);

  // R6: a faulted response carries no address
  assert_fault_zero_addr_R6: assert property (@(posedge clk) disable iff (rst)
    (rspValid && rspFault != FLT_OK) |-> rspAddr == '0);

  // R9: a flush pulse always follows a slot write
  assert_flush_after_write_R9: assert property (@(posedge clk) disable iff (rst)
    flushReq |-> $past(strobe.tblWrite));

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_BITS = 10,
  parameter int OFF_BITS = 22,
  parameter int SID_W    = 30
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfgWrEn,
  input  logic [SEG_BITS-1:0]          cfgIdx,
  input  logic [SID_W-1:0]             cfgSid,
  input  logic [1:0]                   cfgMode,
  input  logic                         reqValid,
  output logic                         reqReady,
  input  logic [SEG_BITS+OFF_BITS-1:0] reqAddr,
  input  logic                         reqWrite,
  output logic                         rspValid,
  output logic [SID_W+OFF_BITS-1:0]    rspAddr,
  output logic [1:0]                   rspFault,
  output logic                         flushReq
);

  strobe_t  strobe;
  segMode_e lookupMode;

  seg_xlate_ctrl i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .cfgWrEn    (cfgWrEn),
    .lookupMode (lookupMode),
    .reqReady   (reqReady),
    .strobe     (strobe)
  );

  seg_xlate_dp #(
    .SEG_BITS (SEG_BITS),
    .OFF_BITS (OFF_BITS),
    .SID_W    (SID_W)
  ) i_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .cfgIdx     (cfgIdx),
    .cfgSid     (cfgSid),
    .cfgMode    (cfgMode),
    .reqAddr    (reqAddr),
    .reqWrite   (reqWrite),
    .lookupMode (lookupMode),
    .rspValid   (rspValid),
    .rspAddr    (rspAddr),
    .rspFault   (rspFault),
    .flushReq   (flushReq)
  );

endmodule

// File: tb/test_seg_xlate.sv
module test_seg_xlate;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgWrEn = 1'b0;
  logic [9:0]  cfgIdx = '0;
  logic [29:0] cfgSid = '0;
  logic [1:0]  cfgMode = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic        rspValid;
  logic [51:0] rspAddr;
  logic [1:0]  rspFault;
  logic        flushReq;

  int checks = 0;
  int errors = 0;

  localparam logic [1:0] M_NONE = 2'b00, M_RO = 2'b01, M_RW = 2'b10, M_COW = 2'b11;
  localparam logic [1:0] F_OK = 2'b00, F_UNM = 2'b01, F_PROT = 2'b10, F_COW = 2'b11;

  always #5 clk = ~clk;

  seg_xlate i_seg_xlate (
    .clk(clk), .rst(rst), .cfgWrEn(cfgWrEn), .cfgIdx(cfgIdx), .cfgSid(cfgSid),
    .cfgMode(cfgMode), .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .rspValid(rspValid), .rspAddr(rspAddr), .rspFault(rspFault),
    .flushReq(flushReq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ea(input logic [9:0] seg, input logic [21:0] off);
    return {seg, off};
  endfunction

  // slot write; returns just after the edge, flushReq already updated
  task automatic slotWrite(input logic [9:0] idx, input logic [29:0] sid, input logic [1:0] mode);
    cfgWrEn = 1'b1; cfgIdx = idx; cfgSid = sid; cfgMode = mode;
    @(posedge clk); #1;
    cfgWrEn = 1'b0;
  endtask

  task automatic access(input string tag, input logic [31:0] a, input logic wr,
                        input logic [29:0] sid, input logic [1:0] expFault);
    logic [51:0] expAddr;
    expAddr = (expFault == F_OK) ? {sid, a[21:0]} : 52'd0;
    reqValid = 1'b1; reqAddr = a; reqWrite = wr;
    @(posedge clk); #1;
    reqValid = 1'b0;
    chk({tag, " rspValid"}, 64'(rspValid), 64'd1);
    chk({tag, " fault"}, 64'(rspFault), 64'(expFault));
    chk({tag, " addr"}, 64'(rspAddr), 64'(expAddr));
  endtask

  task automatic testReset();
    chk("R1 rspValid in reset", 64'(rspValid), 64'd0);
    chk("R1 flushReq in reset", 64'(flushReq), 64'd0);
    rst = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk("R2 reqReady after reset", 64'(reqReady), 64'd1);
    access("R1 slot0 invalid", ea(10'd0, 22'h12345), 1'b0, 30'd0, F_UNM);
    access("R1 slot1023 invalid", ea(10'h3FF, 22'h3FFFFF), 1'b1, 30'd0, F_UNM);
  endtask

  task automatic testModes();
    slotWrite(10'd3, 30'h1234567, M_RW);
    access("R3 R4 rw read", ea(10'd3, 22'h0ABCDE), 1'b0, 30'h1234567, F_OK);
    access("R4 rw write", ea(10'd3, 22'h3FFFFF), 1'b1, 30'h1234567, F_OK);
    access("R3 zero offset", ea(10'd3, 22'h0), 1'b0, 30'h1234567, F_OK);
    slotWrite(10'd5, 30'h2AAAAAA, M_RO);
    access("R4 ro read", ea(10'd5, 22'h000100), 1'b0, 30'h2AAAAAA, F_OK);
    access("R5 R6 ro write", ea(10'd5, 22'h000100), 1'b1, 30'h2AAAAAA, F_PROT);
    slotWrite(10'd7, 30'h3FFFFFF, M_COW);
    access("R4 cow read", ea(10'd7, 22'h155555), 1'b0, 30'h3FFFFFF, F_OK);
    access("R5 R6 cow write", ea(10'd7, 22'h155555), 1'b1, 30'h3FFFFFF, F_COW);
  endtask

  task automatic testIdle();
    @(posedge clk); #1;
    chk("R2 no request no response", 64'(rspValid), 64'd0);
  endtask

  task automatic testAlias();
    slotWrite(10'd9, 30'h2AAAAAA, M_RW);
    access("R8 alias rw write", ea(10'd9, 22'h000100), 1'b1, 30'h2AAAAAA, F_OK);
    access("R8 original still ro", ea(10'd5, 22'h000100), 1'b1, 30'h2AAAAAA, F_PROT);
    access("R8 original read", ea(10'd5, 22'h000200), 1'b0, 30'h2AAAAAA, F_OK);
  endtask

  task automatic testFlush();
    slotWrite(10'd3, 30'h0000D0D, M_RW);
    chk("R9 flush on new sid", 64'(flushReq), 64'd1);
    @(posedge clk); #1;
    chk("R9 flush one cycle", 64'(flushReq), 64'd0);
    slotWrite(10'd3, 30'h0000D0D, M_RO);
    chk("R9 no flush same sid", 64'(flushReq), 64'd0);
    access("R7 new mode used", ea(10'd3, 22'h10), 1'b1, 30'h0000D0D, F_PROT);
    slotWrite(10'd20, 30'h0000BEE, M_RW);
    chk("R9 no flush invalid old", 64'(flushReq), 64'd0);
    slotWrite(10'd3, 30'h0000E0E, M_NONE);
    chk("R9 flush on invalidate", 64'(flushReq), 64'd1);
    access("R5 invalidated slot", ea(10'd3, 22'h10), 1'b0, 30'd0, F_UNM);
  endtask

  task automatic testSameCycle();
    cfgWrEn = 1'b1; cfgIdx = 10'd11; cfgSid = 30'h0123456; cfgMode = M_RW;
    reqValid = 1'b1; reqAddr = ea(10'd11, 22'h2222); reqWrite = 1'b0;
    @(posedge clk); #1;
    cfgWrEn = 1'b0; reqValid = 1'b0;
    chk("R7 same edge valid", 64'(rspValid), 64'd1);
    chk("R7 same edge sees old", 64'(rspFault), 64'(F_UNM));
    access("R7 next request sees new", ea(10'd11, 22'h2222), 1'b0, 30'h0123456, F_OK);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    testModes();
    testIdle();
    testAlias();
    testFlush();
    testSameCycle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule